// File: doc/BRIEF.md
# Converter Fault Latch and Power-Good Status Encoder

This block supervises a step-down converter controller. It takes already digitized comparator flags (undervoltage, overvoltage, overcurrent, short-circuit), a soft-start-in-progress flag, a supply-good flag from the power-on-reset detector and the enable request. From these it drives three outputs:

- a power-good release signal;
- a 2-bit strength code that picks how hard the power-good pin is pulled low, so the kind of fault can be read from the pin's resistance;
- a gate-driver inhibit that holds both switches off.

Overcurrent and short-circuit events latch the converter off. The latch clears only when enable is withdrawn or the supply falls out of power-on-reset.

The block also watches the low-side gate command. A fixed number of clock cycles after that gate goes high, it emits a one-cycle strobe that tells the current-sense path when to sample. All outputs are registered, so each responds one clock after the inputs that cause it.

Top module: `pgfault_supervisor`

## Requirements
- R1: While `por_ok` is low, one clock later `pg_good` is 0, `pd_code` is 2'b00 and `drv_inhibit` is 1. The same values hold after reset.
- R2: Code values: 2'b00 means no pull-down requested. 2'b01 (weakest) is selected for soft-start or undervoltage. 2'b10 (middle) is selected for overvoltage. 2'b11 (strongest) is selected for overcurrent or short-circuit.
- R3: With `por_ok` and `en` high, an `oc_flag` or `sc_flag` seen on a clock edge gives `pd_code`=2'b11 and `drv_inhibit`=1 from the next cycle. Both stay that way after the flags drop.
- R4: The overcurrent latch clears only when `en` or `por_ok` is low. In the cycle after that, `pd_code` is 2'b00, `pg_good` is 0 and `drv_inhibit` is 1. After both return high, the code follows the live flags again.
- R5: When several conditions are present together, the highest one wins. The order is overcurrent/short-circuit, then overvoltage, then undervoltage/soft-start.
- R6: While any condition is still present, a recorded code is never replaced by a lower-priority one. A higher one replaces it at once. When no condition remains and no latch is set, the code returns to 2'b00.
- R7: `pg_good` is 1 only when `por_ok` and `en` are high, no condition is present and no latch is set. `drv_inhibit` is 0 exactly when `por_ok` and `en` are high and no latch is set.
- R8: A rising edge of `lg_gate` sampled at clock edge t gives `sense_strobe` high for exactly one cycle, after edge t+SENSE_DELAY (default 4). This happens only if `lg_gate` stays high through that edge.
- R9: A pending strobe is cancelled if `lg_gate` falls or `drv_inhibit` is 1 before it fires. No strobe is issued while `drv_inhibit` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por_ok | input | 1 | Supply above power-on-reset threshold |
| en | input | 1 | Enable request, high to run |
| ss_active | input | 1 | Soft-start in progress |
| uv_flag | input | 1 | Output undervoltage comparator |
| ov_flag | input | 1 | Output overvoltage comparator |
| oc_flag | input | 1 | Overcurrent comparator |
| sc_flag | input | 1 | Short-circuit comparator (twice the overcurrent setpoint) |
| lg_gate | input | 1 | Low-side gate command from the modulator |
| pg_good | output | 1 | 1 releases the power-good pin |
| pd_code | output | 2 | Pull-down strength select for the power-good pin |
| drv_inhibit | output | 1 | Holds both gate drivers off |
| sense_strobe | output | 1 | One-cycle current-sample strobe |

## Verification
The hardest state to reach from the ports is a sticky lower-priority code that must survive after its cause has gone. Reaching it takes an overvoltage that hands over to an undervoltage without a clean cycle between them, and then a later upgrade to a latched overcurrent. The stimulus builds these overlaps on purpose, step by step. It then releases the latch twice, once through enable and once through the supply flag. For the strobe, low-side pulses shorter than, equal to and longer than the delay are driven, including pulses that start while the latch is set. A long run with biased random flags then compares every cycle against the behavioural model.

// File: rtl/pgfault_pkg.sv
package pgfault_pkg;
  typedef enum logic [1:0] {
    PD_NONE   = 2'b00,
    PD_WEAK   = 2'b01,
    PD_MID    = 2'b10,
    PD_STRONG = 2'b11
  } pd_code_e;
endpackage

// File: rtl/pgfault_trip_latch.sv
module pgfault_trip_latch (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic oc_flag,
  input  logic sc_flag,
  output logic trip_next,
  output logic trip_q,
  output logic inhibit_q
);
  // Short-circuit shares the overcurrent latch path.
  assign trip_next = active & (trip_q | oc_flag | sc_flag);

  always_ff @(posedge clk) begin
    if (rst) begin
      trip_q    <= 1'b0;
      inhibit_q <= 1'b1;
    end else begin
      trip_q    <= trip_next;
      inhibit_q <= ~active | trip_next;
    end
  end
endmodule

// File: rtl/pgfault_code_enc.sv
module pgfault_code_enc
  import pgfault_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     active,
  input  logic     trip_next,
  input  logic     ov_flag,
  input  logic     uv_flag,
  input  logic     ss_active,
  output pd_code_e code_q,
  output logic     pg_q
);
  pd_code_e live_code;
  pd_code_e code_d;
  logic     any_cond;

  always_comb begin
    any_cond = trip_next | ov_flag | uv_flag | ss_active;
    if (trip_next)               live_code = PD_STRONG;
    else if (ov_flag)            live_code = PD_MID;
    else if (uv_flag | ss_active) live_code = PD_WEAK;
    else                         live_code = PD_NONE;

    if (!active || !any_cond)    code_d = PD_NONE;
    else if (code_q > live_code) code_d = code_q;
    else                         code_d = live_code;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= PD_NONE;
      pg_q   <= 1'b0;
    end else begin
      code_q <= code_d;
      pg_q   <= active & ~any_cond;
    end
  end
endmodule

// File: rtl/pgfault_sense_strobe.sv
module pgfault_sense_strobe #(
  parameter int SENSE_DELAY = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic lg_gate,
  output logic strobe_q
);
  localparam int CNT_W = (SENSE_DELAY > 1) ? $clog2(SENSE_DELAY) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(SENSE_DELAY - 1);

  logic             lg_prev;
  logic             armed;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      lg_prev  <= 1'b0;
      armed    <= 1'b0;
      cnt      <= '0;
      strobe_q <= 1'b0;
    end else begin
      lg_prev  <= lg_gate;
      strobe_q <= 1'b0;
      if (!lg_gate || hold) begin
        armed <= 1'b0;
      end else if (!lg_prev) begin
        armed <= 1'b1;
        cnt   <= LOAD;
      end else if (armed) begin
        if (cnt == '0) begin
          strobe_q <= 1'b1;
          armed    <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pgfault_supervisor.sv
module pgfault_supervisor
  import pgfault_pkg::*;
#(
  parameter int SENSE_DELAY = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       por_ok,
  input  logic       en,
  input  logic       ss_active,
  input  logic       uv_flag,
  input  logic       ov_flag,
  input  logic       oc_flag,
  input  logic       sc_flag,
  input  logic       lg_gate,
  output logic       pg_good,
  output logic [1:0] pd_code,
  output logic       drv_inhibit,
  output logic       sense_strobe
);
  logic     active;
  logic     trip_next;
  logic     trip_q;
  pd_code_e code_q;

  assign active = por_ok & en;

  pgfault_trip_latch u_latch (
    .clk       (clk),
    .rst       (rst),
    .active    (active),
    .oc_flag   (oc_flag),
    .sc_flag   (sc_flag),
    .trip_next (trip_next),
    .trip_q    (trip_q),
    .inhibit_q (drv_inhibit)
  );

  pgfault_code_enc u_enc (
    .clk       (clk),
    .rst       (rst),
    .active    (active),
    .trip_next (trip_next),
    .ov_flag   (ov_flag),
    .uv_flag   (uv_flag),
    .ss_active (ss_active),
    .code_q    (code_q),
    .pg_q      (pg_good)
  );

  pgfault_sense_strobe #(.SENSE_DELAY(SENSE_DELAY)) u_strobe (
    .clk      (clk),
    .rst      (rst),
    .hold     (drv_inhibit),
    .lg_gate  (lg_gate),
    .strobe_q (sense_strobe)
  );

  assign pd_code = code_q;
endmodule

// File: rtl/pgfault_supervisor_chk.sv
module pgfault_supervisor_chk (
  input logic       clk,
  input logic       rst,
  input logic       por_ok,
  input logic       en,
  input logic       oc_flag,
  input logic       sc_flag,
  input logic       lg_gate,
  input logic       pg_good,
  input logic [1:0] pd_code,
  input logic       drv_inhibit,
  input logic       sense_strobe
);
  // R1
  por_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(por_ok)) |-> (!pg_good && pd_code == 2'b00 && drv_inhibit));

  // R3
  trip_set_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(por_ok && en && (oc_flag || sc_flag))) |-> (drv_inhibit && pd_code == 2'b11));

  // R4
  trip_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(en)) |-> (pd_code == 2'b00 && !pg_good && drv_inhibit));

  // R6
  strong_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pd_code == 2'b11 && por_ok && en) |=> (pd_code == 2'b11));

  // R7
  pg_clean_chk: assert property (@(posedge clk) disable iff (rst)
    pg_good |-> (pd_code == 2'b00 && !drv_inhibit));

  // R8
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    sense_strobe |=> !sense_strobe);

  // R8
  strobe_lg_chk: assert property (@(posedge clk) disable iff (rst)
    sense_strobe |-> $past(lg_gate));

  // R9
  strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    drv_inhibit |=> !sense_strobe);
endmodule

bind pgfault_supervisor pgfault_supervisor_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .por_ok       (por_ok),
  .en           (en),
  .oc_flag      (oc_flag),
  .sc_flag      (sc_flag),
  .lg_gate      (lg_gate),
  .pg_good      (pg_good),
  .pd_code      (pd_code),
  .drv_inhibit  (drv_inhibit),
  .sense_strobe (sense_strobe)
);

// File: tb/pgfault_supervisor_tb_top.sv
module pgfault_supervisor_tb_top;
  localparam int D = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic por_ok = 1'b0, en = 1'b0, ss_active = 1'b0, uv_flag = 1'b0;
  logic ov_flag = 1'b0, oc_flag = 1'b0, sc_flag = 1'b0, lg_gate = 1'b0;
  logic       pg_good, drv_inhibit, sense_strobe;
  logic [1:0] pd_code;

  int tests = 0;
  int fails = 0;
  bit done  = 0;
  string tag = "R1";

  // reference model state
  int m_code = 0;
  bit m_trip = 0, m_pg = 0, m_inh = 1, m_stb = 0, m_lgp = 0;
  int m_cnt = -1;

  always #2 clk = ~clk;

  pgfault_supervisor #(.SENSE_DELAY(D)) dut_i (
    .clk(clk), .rst(rst), .por_ok(por_ok), .en(en), .ss_active(ss_active),
    .uv_flag(uv_flag), .ov_flag(ov_flag), .oc_flag(oc_flag), .sc_flag(sc_flag),
    .lg_gate(lg_gate), .pg_good(pg_good), .pd_code(pd_code),
    .drv_inhibit(drv_inhibit), .sense_strobe(sense_strobe)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_code = 0; m_trip = 0; m_pg = 0; m_inh = 1; m_stb = 0; m_lgp = 0; m_cnt = -1;
    end else begin
      bit act, any;
      int live;
      act = por_ok && en;
      // strobe uses inhibit as it stood before this edge
      m_stb = 0;
      if (!lg_gate || m_inh) m_cnt = -1;
      else if (!m_lgp) m_cnt = D - 1;
      else if (m_cnt == 0) begin m_stb = 1; m_cnt = -1; end
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
      m_lgp = lg_gate;
      m_trip = act && (m_trip || oc_flag || sc_flag);
      any = m_trip || ov_flag || uv_flag || ss_active;
      live = m_trip ? 3 : ov_flag ? 2 : (uv_flag || ss_active) ? 1 : 0;
      if (!act || !any) m_code = 0;
      else if (m_code < live) m_code = live;
      m_pg = act && !any;
      m_inh = !act || m_trip;
    end
  end

  task automatic chk1(string what, int act_v, int exp_v);
    tests++;
    if (act_v != exp_v) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act_v, exp_v, $time);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk1("pd_code", int'(pd_code), m_code);
      chk1("pg_good", int'(pg_good), int'(m_pg));
      chk1("drv_inhibit", int'(drv_inhibit), int'(m_inh));
      chk1("sense_strobe", int'(sense_strobe), int'(m_stb));
    end
  endtask

  task automatic flags(bit s, bit u, bit o, bit c, bit sc);
    ss_active = s; uv_flag = u; ov_flag = o; oc_flag = c; sc_flag = sc;
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    tag = "R1"; step(3);               // reset values, por low
    en = 1; step(2);
    tag = "R2"; por_ok = 1; flags(1,0,0,0,0); step(3);    // soft-start weak
    tag = "R7"; flags(0,0,0,0,0); step(3);                // good
    tag = "R2"; flags(0,1,0,0,0); step(2);                // uv weak
    flags(0,0,1,0,0); step(2);                            // ov mid
    tag = "R6"; flags(0,1,0,0,0); step(3);                // mid sticks under uv
    flags(0,0,0,0,0); step(2);                            // back to none
    flags(0,1,0,0,0); step(1); flags(0,1,1,0,0); step(2); // upgrade
    tag = "R3"; flags(0,0,0,1,0); step(1); flags(0,0,0,0,0); step(4);
    flags(0,1,1,0,0); step(2);
    tag = "R4"; flags(0,0,0,0,0); en = 0; step(2); en = 1; step(3);
    tag = "R3"; flags(0,0,0,0,1); step(1); flags(0,0,0,0,0); step(3);
    tag = "R4"; por_ok = 0; step(2); por_ok = 1; step(2);
    tag = "R5"; flags(1,1,1,1,0); step(2); en = 0; step(1); en = 1;
    flags(1,1,1,0,0); step(2); flags(0,0,0,0,0); step(2);
    // strobe cases
    tag = "R8"; lg_gate = 1; step(D + 3); lg_gate = 0; step(2);
    lg_gate = 1; step(D + 1); lg_gate = 0; step(2);
    tag = "R9"; lg_gate = 1; step(D - 1); lg_gate = 0; step(D + 2);
    lg_gate = 1; step(2); oc_flag = 1; step(1); oc_flag = 0; step(D + 2);
    lg_gate = 0; step(1); lg_gate = 1; step(D + 2); lg_gate = 0;
    en = 0; step(1); en = 1; step(2);
    // biased random run over all requirements R1..R9 checked against model
    tag = "R5";
    for (int k = 0; k < 3000; k++) begin
      por_ok    = ($urandom % 100) > 1;
      en        = ($urandom % 100) > 3;
      ss_active = ($urandom % 100) < 10;
      uv_flag   = ($urandom % 100) < 12;
      ov_flag   = ($urandom % 100) < 8;
      oc_flag   = ($urandom % 100) < 2;
      sc_flag   = ($urandom % 100) < 1;
      if (($urandom % 100) < 25) lg_gate = ~lg_gate;
      step(1);
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule